// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block is the in-order commit stage of an out-of-order core. Each instruction that issues takes a slot at the tail of a circular buffer. The slot index goes back as a tag that follows the micro-op through execution. Execution units report completion by tag, with a result and an exception flag. The oldest slot retires once its result is present. Retirement drives an architectural register write or releases a buffered store by tag. The rest of the pipeline sees results only in program order.

The buffer also answers operand lookups. A source register is compared against every in-flight producer. The youngest live match supplies its value if the value is known, and its tag if not. A result written back in the same cycle counts as known.

Branches enter with a predicted direction and hold the head until they resolve. A mispredicted resolution marks every younger slot dead, including slots issued before the branch retires. Dead slots drain one per cycle with no effect. The front end is redirected to the correct path when the branch retires. An exception found at the head discards the whole buffer and redirects to the faulting PC.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `iss_ready_o` is 1, `iss_tag_o` is 0, no retirement, store release or redirect is signalled, and lookups miss.
- R2: An accepted issue takes the tail slot, whose index is shown on `iss_tag_o` in that cycle. Tags advance by one per accepted issue and wrap modulo DEPTH.
- R3: `iss_ready_o` is 0 while DEPTH slots are occupied, and also in a cycle in which an exception is retiring.
- R4: Only the head slot retires, at most one per cycle, and a live head waits until its result is written. A register-writing slot (kind 2'b00) asserts `ret_reg_we_o` with its destination and result, so results written back out of order retire in issue order.
- R5: A live store slot (kind 2'b01) retires by pulsing `ret_store_o` with its tag on `ret_store_tag_o`. It writes no register.
- R6: A live head whose completion carried the exception flag retires with `redir_valid_o`=1, `redir_exc_o`=1 and `redir_pc_o` set to its issue PC. It writes nothing, and every slot is discarded, so the next issue gets tag 0.
- R7: A lookup reports the youngest live register-writing slot whose destination equals `lk_reg_i`. When the result is present it gives `lk_ready_o`=1 and the result on `lk_data_o`. Otherwise it gives `lk_ready_o`=0, and the tag is on `lk_tag_o` in both cases. With no match, `lk_hit_o` is 0.
- R8: A completion in the same cycle as a lookup of the same slot is forwarded: `lk_ready_o`=1 and `lk_data_o` equals `cmp_data_i`.
- R9: A branch slot (kind 2'b10) stays at the head until completed. When `cmp_taken_i` equals the prediction, it retires with no output and later slots retire normally.
- R10: When a live branch completes with `cmp_taken_i` different from its prediction, every younger slot becomes dead. So does every slot issued from that cycle until the branch retires. At retirement the branch pulses `redir_valid_o` with `redir_exc_o`=0 and `redir_pc_o` set to its completion data. Dead slots retire one per cycle, completed or not, with no output.
- R11: Dead slots are never returned by a lookup; an older live producer of the same register is returned instead.
- R12: In any cycle at most one of `ret_reg_we_o`, `ret_store_o` and `redir_valid_o` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Issue request |
| iss_kind_i | input | 2 | 00 register write, 01 store, 10 branch |
| iss_dst_i | input | AREG_W | Destination architectural register |
| iss_pc_i | input | PC_W | PC of the issuing instruction |
| iss_pred_i | input | 1 | Predicted branch direction |
| iss_ready_o | output | 1 | Issue can be accepted |
| iss_tag_o | output | log2(DEPTH) | Tag assigned to the issue |
| cmp_valid_i | input | 1 | Completion writeback |
| cmp_tag_i | input | log2(DEPTH) | Tag of the completing slot |
| cmp_data_i | input | DATA_W | Result, or correct next PC for a branch |
| cmp_exc_i | input | 1 | Completion raised an exception |
| cmp_taken_i | input | 1 | Resolved branch direction |
| lk_reg_i | input | AREG_W | Source register looked up |
| lk_hit_o | output | 1 | A live in-flight producer exists |
| lk_ready_o | output | 1 | Producer's value is available |
| lk_tag_o | output | log2(DEPTH) | Producer's tag |
| lk_data_o | output | DATA_W | Producer's value |
| ret_reg_we_o | output | 1 | Architectural register write |
| ret_reg_addr_o | output | AREG_W | Register written |
| ret_reg_data_o | output | DATA_W | Value written |
| ret_store_o | output | 1 | Release a buffered store |
| ret_store_tag_o | output | log2(DEPTH) | Tag of the released store |
| redir_valid_o | output | 1 | Front-end redirect pulse |
| redir_exc_o | output | 1 | Redirect is due to an exception |
| redir_pc_o | output | PC_W | Redirect target |

## Verification
Completion and lookup collide when an execution unit writes back the very slot a lookup is resolving. The bench provokes this on purpose in the directed phase and at random in the long phase. The reference model counts the lookup as ready, with the written-back data, exactly when the completion tag matches the youngest live producer. A mispredicting completion can also coincide with an issue. The model expects that issue to come in dead, and it checks that the slot later drains silently and never answers a lookup.

// File: rtl/spec_rob_pkg.sv
package spec_rob_pkg;
  typedef enum logic [1:0] {
    K_REG    = 2'b00,
    K_STORE  = 2'b01,
    K_BRANCH = 2'b10,
    K_NONE   = 2'b11
  } op_kind_e;
endpackage

// File: rtl/spec_rob_ptr.sv
module spec_rob_ptr #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (clr_i)  ptr_o <= '0;
    else if (inc_i)  ptr_o <= ptr_o + 1'b1;
  end
endmodule

// File: rtl/spec_rob_lookup.sv
module spec_rob_lookup #(
  parameter int DEPTH  = 8,
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic [IDX_W-1:0]  head_i,
  input  logic [PTR_W-1:0]  count_i,
  input  logic [DEPTH-1:0]  cand_i,
  input  logic [DEPTH-1:0]  rdy_i,
  input  logic [AREG_W-1:0] dst_i  [DEPTH],
  input  logic [DATA_W-1:0] data_i [DEPTH],
  input  logic              cmp_valid_i,
  input  logic [IDX_W-1:0]  cmp_tag_i,
  input  logic [DATA_W-1:0] cmp_data_i,
  input  logic [AREG_W-1:0] reg_i,
  output logic              hit_o,
  output logic              ready_o,
  output logic [IDX_W-1:0]  tag_o,
  output logic [DATA_W-1:0] data_o
);
  logic [IDX_W-1:0] idx;
  logic             fwd;

  // walk oldest to youngest; last match wins
  always_comb begin
    hit_o = 1'b0;
    tag_o = '0;
    idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = head_i + IDX_W'(i);
      if (i < int'(count_i) && cand_i[idx] && dst_i[idx] == reg_i) begin
        hit_o = 1'b1;
        tag_o = idx;
      end
    end
  end

  assign fwd     = cmp_valid_i && (cmp_tag_i == tag_o);
  assign ready_o = hit_o && (rdy_i[tag_o] || fwd);
  assign data_o  = rdy_i[tag_o] ? data_i[tag_o] : cmp_data_i;
endmodule

// File: rtl/spec_rob_retire.sv
module spec_rob_retire
  import spec_rob_pkg::*;
(
  input  logic     empty_i,
  input  logic     live_i,
  input  logic     rdy_i,
  input  logic     exc_i,
  input  logic     mis_i,
  input  op_kind_e kind_i,
  output logic     retire_o,
  output logic     reg_we_o,
  output logic     store_o,
  output logic     redir_o,
  output logic     flush_o
);
  always_comb begin
    retire_o = 1'b0;
    reg_we_o = 1'b0;
    store_o  = 1'b0;
    redir_o  = 1'b0;
    flush_o  = 1'b0;
    if (!empty_i) begin
      if (!live_i) begin
        retire_o = 1'b1;  // squashed: drain silently
      end else if (rdy_i) begin
        retire_o = 1'b1;
        if (exc_i) begin
          redir_o = 1'b1;
          flush_o = 1'b1;
        end else begin
          case (kind_i)
            K_REG:    reg_we_o = 1'b1;
            K_STORE:  store_o  = 1'b1;
            K_BRANCH: redir_o  = mis_i;
            default:  ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import spec_rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic [1:0]        iss_kind_i,
  input  logic [AREG_W-1:0] iss_dst_i,
  input  logic [PC_W-1:0]   iss_pc_i,
  input  logic              iss_pred_i,
  output logic              iss_ready_o,
  output logic [IDX_W-1:0]  iss_tag_o,
  input  logic              cmp_valid_i,
  input  logic [IDX_W-1:0]  cmp_tag_i,
  input  logic [DATA_W-1:0] cmp_data_i,
  input  logic              cmp_exc_i,
  input  logic              cmp_taken_i,
  input  logic [AREG_W-1:0] lk_reg_i,
  output logic              lk_hit_o,
  output logic              lk_ready_o,
  output logic [IDX_W-1:0]  lk_tag_o,
  output logic [DATA_W-1:0] lk_data_o,
  output logic              ret_reg_we_o,
  output logic [AREG_W-1:0] ret_reg_addr_o,
  output logic [DATA_W-1:0] ret_reg_data_o,
  output logic              ret_store_o,
  output logic [IDX_W-1:0]  ret_store_tag_o,
  output logic              redir_valid_o,
  output logic              redir_exc_o,
  output logic [PC_W-1:0]   redir_pc_o
);
  logic [DEPTH-1:0]  vld_q, live_q, rdy_q, exc_q, mis_q, pred_q;
  op_kind_e          kind_q [DEPTH];
  logic [AREG_W-1:0] dst_q  [DEPTH];
  logic [PC_W-1:0]   pc_q   [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic              kill_q;

  logic [PTR_W-1:0]  head_ptr, tail_ptr, count;
  logic [IDX_W-1:0]  head_idx, tail_idx, cmp_age;
  logic              full, empty, iss_fire, retire, flush;
  logic              cmp_hit, kill_now, mis_res, redir;
  logic [DEPTH-1:0]  cand, younger;

  assign head_idx = head_ptr[IDX_W-1:0];
  assign tail_idx = tail_ptr[IDX_W-1:0];
  assign count    = tail_ptr - head_ptr;
  assign full     = (count == PTR_W'(DEPTH));
  assign empty    = (count == '0);

  assign iss_ready_o = !full && !flush;
  assign iss_tag_o   = tail_idx;
  assign iss_fire    = iss_valid_i && iss_ready_o;

  spec_rob_ptr #(.DEPTH(DEPTH)) u_head (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(retire), .clr_i(flush), .ptr_o(head_ptr));
  spec_rob_ptr #(.DEPTH(DEPTH)) u_tail (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(iss_fire), .clr_i(flush), .ptr_o(tail_ptr));

  // completion and misprediction detection
  assign cmp_hit  = cmp_valid_i && vld_q[cmp_tag_i] && !flush;
  assign mis_res  = (kind_q[cmp_tag_i] == K_BRANCH) && (cmp_taken_i != pred_q[cmp_tag_i]);
  assign kill_now = cmp_hit && live_q[cmp_tag_i] && mis_res;
  assign cmp_age  = cmp_tag_i - head_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign cand[g]    = vld_q[g] && live_q[g] && (kind_q[g] == K_REG);
    assign younger[g] = vld_q[g] && ((IDX_W'(g) - head_idx) > cmp_age);
  end

  spec_rob_retire u_retire (
    .empty_i (empty),
    .live_i  (live_q[head_idx]),
    .rdy_i   (rdy_q[head_idx]),
    .exc_i   (exc_q[head_idx]),
    .mis_i   (mis_q[head_idx]),
    .kind_i  (kind_q[head_idx]),
    .retire_o(retire),
    .reg_we_o(ret_reg_we_o),
    .store_o (ret_store_o),
    .redir_o (redir),
    .flush_o (flush)
  );

  assign ret_reg_addr_o  = dst_q[head_idx];
  assign ret_reg_data_o  = data_q[head_idx];
  assign ret_store_tag_o = head_idx;
  assign redir_valid_o   = redir;
  assign redir_exc_o     = flush;
  assign redir_pc_o      = flush ? pc_q[head_idx] : PC_W'(data_q[head_idx]);

  spec_rob_lookup #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W)) u_lookup (
    .head_i     (head_idx),
    .count_i    (count),
    .cand_i     (cand),
    .rdy_i      (rdy_q),
    .dst_i      (dst_q),
    .data_i     (data_q),
    .cmp_valid_i(cmp_valid_i),
    .cmp_tag_i  (cmp_tag_i),
    .cmp_data_i (cmp_data_i),
    .reg_i      (lk_reg_i),
    .hit_o      (lk_hit_o),
    .ready_o    (lk_ready_o),
    .tag_o      (lk_tag_o),
    .data_o     (lk_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      live_q <= '0;
      rdy_q  <= '0;
      exc_q  <= '0;
      mis_q  <= '0;
      kill_q <= 1'b0;
    end else if (flush) begin
      vld_q  <= '0;
      kill_q <= 1'b0;
    end else begin
      if (retire) vld_q[head_idx] <= 1'b0;
      if (cmp_hit) begin
        rdy_q[cmp_tag_i] <= 1'b1;
        exc_q[cmp_tag_i] <= cmp_exc_i;
        mis_q[cmp_tag_i] <= mis_res;
      end
      if (kill_now) live_q <= live_q & ~younger;
      if (iss_fire) begin
        vld_q[tail_idx]  <= 1'b1;
        live_q[tail_idx] <= !(kill_q || kill_now);
        rdy_q[tail_idx]  <= 1'b0;
        exc_q[tail_idx]  <= 1'b0;
        mis_q[tail_idx]  <= 1'b0;
      end
      if (kill_now)   kill_q <= 1'b1;
      else if (redir) kill_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (cmp_hit) data_q[cmp_tag_i] <= cmp_data_i;
    if (iss_fire) begin
      kind_q[tail_idx] <= op_kind_e'(iss_kind_i);
      dst_q[tail_idx]  <= iss_dst_i;
      pc_q[tail_idx]   <= iss_pc_i;
      pred_q[tail_idx] <= iss_pred_i;
    end
  end
endmodule

// File: rtl/spec_rob_chk.sv
module spec_rob_chk #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PTR_W-1:0] count_i,
  input logic             iss_fire_i,
  input logic             retire_i,
  input logic             ret_reg_we_i,
  input logic             ret_store_i,
  input logic             redir_valid_i,
  input logic             redir_exc_i
);
  // R12
  one_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ret_reg_we_i, ret_store_i, redir_valid_i}));

  // R3
  occupancy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= PTR_W'(DEPTH));

  // R2
  issue_grows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_fire_i && !retire_i) |=> count_i == $past(count_i) + 1'b1);

  // R6
  exc_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redir_valid_i && redir_exc_i) |=> count_i == '0);

  // R10
  redirect_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redir_valid_i && !redir_exc_i) |=> !redir_valid_i);

  // R4
  empty_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == '0) |-> !(ret_reg_we_i || ret_store_i || redir_valid_i));
endmodule

bind spec_rob spec_rob_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .count_i      (count),
  .iss_fire_i   (iss_fire),
  .retire_i     (retire),
  .ret_reg_we_i (ret_reg_we_o),
  .ret_store_i  (ret_store_o),
  .redir_valid_i(redir_valid_o),
  .redir_exc_i  (redir_exc_o)
);

// File: tb/spec_rob_test.sv
`timescale 1ns/1ps
module spec_rob_test;
  localparam int DEPTH = 8;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int PW = 32;
  localparam int TW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic iss_valid_i = 0, iss_pred_i = 0;
  logic [1:0] iss_kind_i = 0;
  logic [AW-1:0] iss_dst_i = 0;
  logic [PW-1:0] iss_pc_i = 0;
  logic iss_ready_o;
  logic [TW-1:0] iss_tag_o;
  logic cmp_valid_i = 0, cmp_exc_i = 0, cmp_taken_i = 0;
  logic [TW-1:0] cmp_tag_i = 0;
  logic [DW-1:0] cmp_data_i = 0;
  logic [AW-1:0] lk_reg_i = 0;
  logic lk_hit_o, lk_ready_o;
  logic [TW-1:0] lk_tag_o;
  logic [DW-1:0] lk_data_o;
  logic ret_reg_we_o, ret_store_o, redir_valid_o, redir_exc_o;
  logic [AW-1:0] ret_reg_addr_o;
  logic [DW-1:0] ret_reg_data_o;
  logic [TW-1:0] ret_store_tag_o;
  logic [PW-1:0] redir_pc_o;

  spec_rob #(.DEPTH(DEPTH), .AREG_W(AW), .DATA_W(DW), .PC_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .iss_valid_i(iss_valid_i), .iss_kind_i(iss_kind_i), .iss_dst_i(iss_dst_i),
    .iss_pc_i(iss_pc_i), .iss_pred_i(iss_pred_i), .iss_ready_o(iss_ready_o),
    .iss_tag_o(iss_tag_o), .cmp_valid_i(cmp_valid_i), .cmp_tag_i(cmp_tag_i),
    .cmp_data_i(cmp_data_i), .cmp_exc_i(cmp_exc_i), .cmp_taken_i(cmp_taken_i),
    .lk_reg_i(lk_reg_i), .lk_hit_o(lk_hit_o), .lk_ready_o(lk_ready_o),
    .lk_tag_o(lk_tag_o), .lk_data_o(lk_data_o), .ret_reg_we_o(ret_reg_we_o),
    .ret_reg_addr_o(ret_reg_addr_o), .ret_reg_data_o(ret_reg_data_o),
    .ret_store_o(ret_store_o), .ret_store_tag_o(ret_store_tag_o),
    .redir_valid_o(redir_valid_o), .redir_exc_o(redir_exc_o), .redir_pc_o(redir_pc_o));

  always #2.5 clk = ~clk;

  typedef struct {
    int tag; int kind; int dst;
    logic [31:0] pc; logic [31:0] data;
    bit rdy; bit exc; bit live; bit pred; bit mis;
  } ent_t;

  ent_t q[$];
  int next_tag = 0;
  bit kill = 0;
  int n_chk = 0, n_err = 0, cyc_cnt = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // reference model: compare combinational outputs, then advance state
  task automatic model_step();
    int n = q.size();
    bit flush = 0, ret = 0, we = 0, st = 0, rd = 0, rx = 0, hit = 0, rdy = 0;
    bit fwd = 0, dead_skip = 0, kill_now = 0, exp_ready;
    logic [31:0] wd = 0, rpc = 0, ld = 0;
    int wa = 0, stag = 0, sel = 0, pos = -1;
    string rq = "R4", lq = "R7";
    if (n > 0) begin
      ent_t h = q[0];
      if (!h.live) begin ret = 1; rq = "R10"; end
      else if (h.rdy) begin
        ret = 1;
        if (h.exc) begin rd = 1; rx = 1; rpc = h.pc; flush = 1; rq = "R6"; end
        else case (h.kind)
          0: begin we = 1; wa = h.dst; wd = h.data; rq = "R4"; end
          1: begin st = 1; stag = h.tag; rq = "R5"; end
          default: begin rd = h.mis; rpc = h.data; rq = h.mis ? "R10" : "R9"; end
        endcase
      end else if (h.kind == 2) rq = "R9";
    end
    exp_ready = (n < DEPTH) && !flush;
    for (int k = 0; k < n; k++) begin
      if (q[k].kind == 0 && q[k].dst == int'(lk_reg_i)) begin
        if (q[k].live) begin hit = 1; sel = k; end
        else dead_skip = 1;
      end
    end
    if (hit) begin
      fwd = !q[sel].rdy && cmp_valid_i && int'(cmp_tag_i) == q[sel].tag;
      rdy = q[sel].rdy || fwd;
      ld  = q[sel].rdy ? q[sel].data : cmp_data_i;
    end
    lq = fwd ? "R8" : (dead_skip ? "R11" : "R7");

    chk(iss_ready_o == exp_ready, "R3", "iss_ready", iss_ready_o, exp_ready);
    chk(int'(iss_tag_o) == next_tag, "R2", "iss_tag", iss_tag_o, next_tag);
    chk(ret_reg_we_o == we, rq, "ret_reg_we", ret_reg_we_o, we);
    if (we) begin
      chk(int'(ret_reg_addr_o) == wa, "R4", "ret_reg_addr", ret_reg_addr_o, wa);
      chk(ret_reg_data_o == wd, "R4", "ret_reg_data", ret_reg_data_o, wd);
    end
    chk(ret_store_o == st, rq, "ret_store", ret_store_o, st);
    if (st) chk(int'(ret_store_tag_o) == stag, "R5", "ret_store_tag", ret_store_tag_o, stag);
    chk(redir_valid_o == rd, rq, "redir_valid", redir_valid_o, rd);
    if (rd) begin
      chk(redir_exc_o == rx, rq, "redir_exc", redir_exc_o, rx);
      chk(redir_pc_o == rpc, rq, "redir_pc", redir_pc_o, rpc);
    end
    chk($countones({ret_reg_we_o, ret_store_o, redir_valid_o}) <= 1, "R12", "one_effect",
        {ret_reg_we_o, ret_store_o, redir_valid_o}, 0);
    chk(lk_hit_o == hit, lq, "lk_hit", lk_hit_o, hit);
    if (hit) begin
      chk(int'(lk_tag_o) == q[sel].tag, lq, "lk_tag", lk_tag_o, q[sel].tag);
      chk(lk_ready_o == rdy, lq, "lk_ready", lk_ready_o, rdy);
      if (rdy) chk(lk_data_o == ld, lq, "lk_data", lk_data_o, ld);
    end

    if (flush) begin
      q.delete();
      next_tag = 0;
      kill = 0;
    end else begin
      if (cmp_valid_i)
        for (int k = 0; k < n; k++) if (q[k].tag == int'(cmp_tag_i)) pos = k;
      if (pos >= 0) begin
        q[pos].rdy = 1; q[pos].data = cmp_data_i; q[pos].exc = cmp_exc_i;
        q[pos].mis = (q[pos].kind == 2) && (cmp_taken_i != q[pos].pred);
        if (q[pos].live && q[pos].mis) begin
          kill_now = 1;
          for (int k = pos + 1; k < n; k++) q[pos + (k - pos)].live = 0;
        end
      end
      if (ret) void'(q.pop_front());
      if (iss_valid_i && exp_ready) begin
        ent_t e;
        e.tag = next_tag; e.kind = int'(iss_kind_i); e.dst = int'(iss_dst_i);
        e.pc = iss_pc_i; e.data = 0; e.rdy = 0; e.exc = 0; e.mis = 0;
        e.live = !(kill || kill_now); e.pred = iss_pred_i;
        q.push_back(e);
        next_tag = (next_tag + 1) % DEPTH;
      end
      if (kill_now) kill = 1;
      else if (rd && !rx) kill = 0;
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    #0.5;
    model_step();
    @(posedge clk);
    #0.5;
    iss_valid_i = 0;
    cmp_valid_i = 0;
    cmp_exc_i = 0;
  endtask

  task automatic iss(input int kind, input int dst, input logic [31:0] pc, input bit pred);
    iss_valid_i = 1; iss_kind_i = 2'(kind); iss_dst_i = AW'(dst);
    iss_pc_i = pc; iss_pred_i = pred;
  endtask

  task automatic cmp(input int tag, input logic [31:0] d, input bit exc, input bit taken);
    cmp_valid_i = 1; cmp_tag_i = TW'(tag); cmp_data_i = d;
    cmp_exc_i = exc; cmp_taken_i = taken;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000 && !done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc_cnt, 100000);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5;
    // R1 reset state
    chk(iss_ready_o == 1'b1, "R1", "iss_ready", iss_ready_o, 1);
    chk(iss_tag_o == '0, "R1", "iss_tag", iss_tag_o, 0);
    chk(ret_reg_we_o == 1'b0, "R1", "ret_reg_we", ret_reg_we_o, 0);
    chk(ret_store_o == 1'b0, "R1", "ret_store", ret_store_o, 0);
    chk(redir_valid_o == 1'b0, "R1", "redir_valid", redir_valid_o, 0);
    chk(lk_hit_o == 1'b0, "R1", "lk_hit", lk_hit_o, 0);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #0.5;

    // R2 R4 R7 R8: out-of-order completion, youngest producer, same-cycle forward
    iss(0, 1, 32'h100, 0); cyc();
    iss(0, 2, 32'h104, 0); cyc();
    iss(0, 1, 32'h108, 0); cyc();
    lk_reg_i = 1; cyc();
    cmp(2, 32'hAA, 0, 0); cyc();
    lk_reg_i = 2; cmp(1, 32'hBB, 0, 0); cyc();
    cmp(0, 32'hCC, 0, 0); cyc();
    lk_reg_i = 1; idle(4);

    // R3: fill to capacity, then try one more
    for (int i = 0; i < DEPTH; i++) begin iss(0, i, 32'h200 + i * 4, 0); cyc(); end
    iss(0, 9, 32'h300, 0); cyc();
    for (int i = DEPTH - 1; i >= 0; i--) begin cmp((3 + i) % DEPTH, 32'h1000 + i, 0, 0); cyc(); end
    idle(DEPTH + 2);

    // R5: store release
    iss(1, 0, 32'h400, 0); cyc();
    cmp(next_tag == 0 ? DEPTH - 1 : next_tag - 1, 32'h0, 0, 0); cyc();
    idle(2);

    // R9: correct branch blocks head until resolved
    begin
      int bt = next_tag;
      iss(2, 0, 32'h500, 1); cyc();
      iss(0, 5, 32'h504, 0); cyc();
      idle(2);
      cmp((bt + 1) % DEPTH, 32'h55, 0, 0); cyc();
      idle(1);
      cmp(bt, 32'h600, 0, 1); cyc();
      idle(3);
    end

    // R10 R11: mispredict squashes younger and late issues
    begin
      int t0 = next_tag;
      iss(0, 3, 32'h700, 0); cyc();
      iss(2, 0, 32'h704, 0); cyc();
      iss(0, 3, 32'h708, 0); cyc();
      iss(1, 0, 32'h70C, 0); cyc();
      lk_reg_i = 3; cmp((t0 + 1) % DEPTH, 32'h2000, 0, 1); iss(0, 3, 32'h710, 0); cyc();
      iss(0, 3, 32'h714, 0); cyc();
      cyc();
      cmp(t0, 32'h77, 0, 0); cyc();
      idle(2);
      iss(0, 3, 32'h2000, 0); cyc();
      idle(6);
    end

    // R6: exception at head flushes everything
    begin
      int t0 = next_tag;
      iss(0, 6, 32'h800, 0); cyc();
      iss(0, 7, 32'h804, 0); cyc();
      iss(1, 0, 32'h808, 0); cyc();
      cmp((t0 + 1) % DEPTH, 32'h9, 0, 0); cyc();
      lk_reg_i = 7; cmp(t0, 32'h8, 1, 0); iss(0, 7, 32'h80C, 0); cyc();
      iss(0, 7, 32'h900, 0); cyc();
      idle(1);
      cmp(0, 32'h91, 0, 0); cyc();
      idle(2);
    end

    // random phase
    for (int c = 0; c < 4000; c++) begin
      int nr = 0;
      int cands[$];
      if ($urandom_range(1, 0) == 1)
        iss($urandom_range(2, 0), $urandom_range(7, 0), $urandom, $urandom_range(1, 0) == 1);
      foreach (q[k]) if (!q[k].rdy) cands.push_back(q[k].tag);
      nr = cands.size();
      if (nr > 0 && $urandom_range(2, 0) != 0)
        cmp(cands[$urandom_range(nr - 1, 0)], $urandom, $urandom_range(39, 0) == 0,
            $urandom_range(1, 0) == 1);
      lk_reg_i = AW'($urandom_range(7, 0));
      cyc();
    end
    idle(2 * DEPTH);

    done = 1;
    summary();
    $finish;
  end
endmodule